// File: doc/BRIEF.md
# Write-Snoop Cache Line Invalidator

This block watches the write-address channel of an accelerator's AXI master port. That port reaches memory directly and does not pass through the scalar core's write-through L1 data cache. For every accepted write burst, the block works out which cache lines the burst touches. It then offers them one at a time to the scalar core as invalidation requests, each with a valid/ready handshake and a line-aligned address. The lines are clean copies in a write-through cache, so discarding them never needs a writeback.

The block is purely an observer. It never drives the write-address ready and never stalls the snooped channel. Accepted bursts wait in a small queue that decouples the AXI side from the cache side. A line walker then steps through each queued burst.

The walker is a two-state machine. State `WK_IDLE` means no invalidation is offered. State `WK_EMIT` means the current line is offered. Its transitions are:
- **load**: from `WK_IDLE` to `WK_EMIT`, when the path is enabled and the queue holds a burst.
- **step**: `WK_EMIT` stays in `WK_EMIT` and moves to the next line after a handshake on a line that is not the last.
- **chain**: `WK_EMIT` stays in `WK_EMIT` and loads the next queued burst after a handshake on a burst's last line.
- **finish**: from `WK_EMIT` to `WK_IDLE`, after a handshake on a last line when the queue is empty.
- **flush**: from either state to `WK_IDLE`, whenever the consistency enable is low.

A runtime consistency enable gates the whole path.

Top module: `aw_snoop_inval`

## Requirements
- R1: After a synchronous reset (rst_ni low at a clock edge), inval_valid_o and aw_lost_o are both low.
- R2: A write-address beat is taken only on a clock edge where snoop_aw_valid_i and snoop_aw_ready_i are both high. A valid held without ready produces no invalidation.
- R3: For an INCR burst (burst code 2'b01), the byte span runs from addr to addr + (len+1)·2^size − 1. One invalidation is emitted for each 64-byte line this span touches, in ascending order. Each inval_addr_o is the line base, with its low 6 bits zero. A span that runs past the top of the address space stops at the last line.
- R4: A FIXED burst (burst code 2'b00) yields exactly one invalidation, for the line that holds addr, whatever len is.
- R5: A WRAP burst (burst code 2'b10) yields the lines of the window (len+1)·2^size bytes long, aligned to its own size (a power of two), that holds addr, in ascending order from the window base. The reserved code 2'b11 is handled as INCR.
- R6: While inval_valid_o is high and inval_ready_i is low, inval_valid_o and inval_addr_o stay unchanged. Within a burst, the next line's address is presented in the cycle right after the handshake.
- R7: If a beat is taken at clock edge k while the walker is idle and the queue is empty, the first invalidation is offered from edge k+1 on.
- R8: While cons_en_i is low, inval_valid_o is low and taken beats are not queued.
- R9: A clock edge with cons_en_i low empties the queue and stops the walker. No line of a burst taken before that edge is offered afterwards.
- R10: The queue holds 4 bursts, not counting the one in the walker. A beat taken while the queue holds 4 bursts is dropped, even if the walker pops at that edge. The drop sets aw_lost_o, which stays high until reset.
- R11: After the handshake on a burst's last line, if another burst is queued, that burst's first line is offered in the next cycle with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| cons_en_i | input | 1 | Consistency enable for the invalidation path |
| snoop_aw_valid_i | input | 1 | Snooped write-address valid |
| snoop_aw_ready_i | input | 1 | Snooped write-address ready |
| snoop_aw_addr_i | input | ADDR_W | Snooped burst start address |
| snoop_aw_len_i | input | 8 | Snooped beat count minus one |
| snoop_aw_size_i | input | 3 | Snooped log2 of bytes per beat |
| snoop_aw_burst_i | input | 2 | Snooped burst type |
| inval_valid_o | output | 1 | Invalidation request valid |
| inval_addr_o | output | ADDR_W | Line-aligned address to invalidate |
| inval_ready_i | input | 1 | Cache accepts the invalidation |
| aw_lost_o | output | 1 | Sticky flag: a snooped burst was dropped |

## Verification
A beat taken at edge k is queued after k, and its first line is offered after k+1. Each following line of the burst appears one edge after the previous line's handshake. Disabling takes effect on the output at once and clears the state at the next edge.

All stimulus and ready values change at the falling edge. The scoreboard compares a line only on a falling edge where valid and ready are both high, which is the handshake the next rising edge completes.

The latency and back-to-back checks count falling edges from the driving task's return. They expect valid low at the first falling edge and high at the second. They expect the two handshakes of chained bursts on consecutive cycles.

// File: rtl/aw_snoop_pkg.sv
package aw_snoop_pkg;

    typedef enum logic [1:0] {
        BURST_FIXED = 2'b00,
        BURST_INCR  = 2'b01,
        BURST_WRAP  = 2'b10,
        BURST_RSVD  = 2'b11
    } burst_e;

    typedef enum logic {
        WK_IDLE = 1'b0,
        WK_EMIT = 1'b1
    } walk_state_e;

    localparam int unsigned AXI_LEN_W  = 8;
    localparam int unsigned AXI_SIZE_W = 3;

endpackage

// File: rtl/aw_span_calc.sv
module aw_span_calc
    import aw_snoop_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LINE_W = 6,
    localparam int unsigned IDX_W = ADDR_W - LINE_W
) (
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [AXI_LEN_W-1:0]  len_i,
    input  logic [AXI_SIZE_W-1:0] size_i,
    input  logic [1:0]            burst_i,
    output logic [IDX_W-1:0]      first_o,
    output logic [IDX_W-1:0]      last_o
);
    localparam int unsigned SPAN_W = AXI_LEN_W + 1 + (1 << AXI_SIZE_W) - 1;

    logic [SPAN_W-1:0]   span_bytes;
    logic [ADDR_W:0]     span_ext;
    logic [ADDR_W-1:0]   wrap_mask;
    logic [ADDR_W:0]     lo_ext;
    logic [ADDR_W:0]     hi_ext;

    assign span_bytes = SPAN_W'({1'b0, len_i} + 9'd1) << size_i;
    assign span_ext   = (ADDR_W + 1)'(span_bytes);
    assign wrap_mask  = span_ext[ADDR_W-1:0] - 1'b1;

    always_comb begin
        lo_ext = {1'b0, addr_i};
        hi_ext = {1'b0, addr_i};
        unique case (burst_e'(burst_i))
            BURST_FIXED: begin
                lo_ext = {1'b0, addr_i};
                hi_ext = {1'b0, addr_i};
            end
            BURST_WRAP: begin
                lo_ext = {1'b0, addr_i & ~wrap_mask};
                hi_ext = lo_ext + span_ext - 1'b1;
            end
            BURST_INCR, BURST_RSVD: begin
                lo_ext = {1'b0, addr_i};
                hi_ext = lo_ext + span_ext - 1'b1;
            end
        endcase
    end

    assign first_o = lo_ext[ADDR_W-1:LINE_W];
    assign last_o  = hi_ext[ADDR_W] ? {IDX_W{1'b1}} : hi_ext[ADDR_W-1:LINE_W];

endmodule

// File: rtl/aw_burst_queue.sv
module aw_burst_queue #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned IDX_W = 26,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             push_i,
    input  logic [IDX_W-1:0] push_first_i,
    input  logic [IDX_W-1:0] push_last_i,
    input  logic             pop_i,
    output logic             empty_o,
    output logic [IDX_W-1:0] head_first_o,
    output logic [IDX_W-1:0] head_last_o,
    output logic             lost_o
);
    logic [IDX_W-1:0] first_mem [DEPTH];
    logic [IDX_W-1:0] last_mem  [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             lost_q;
    logic             full, accept, drop, take;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign empty_o = (cnt_q == '0);
    assign accept  = push_i && en_i && !full;
    assign drop    = push_i && en_i && full;
    assign take    = pop_i && en_i && !empty_o;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
            lost_q   <= 1'b0;
        end else if (!en_i) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (accept) wr_ptr_q <= bump(wr_ptr_q);
            if (take)   rd_ptr_q <= bump(rd_ptr_q);
            unique case ({accept, take})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
            if (drop) lost_q <= 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (accept) begin
            first_mem[wr_ptr_q] <= push_first_i;
            last_mem[wr_ptr_q]  <= push_last_i;
        end
    end

    assign head_first_o = first_mem[rd_ptr_q];
    assign head_last_o  = last_mem[rd_ptr_q];
    assign lost_o       = lost_q;

    // R10
    cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= CNT_W'(DEPTH));

    // R10
    lost_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lost_q |=> lost_q);

    // R9
    queue_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> empty_o);

    // R10
    full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && push_i && full && !take) |=> full);

endmodule

// File: rtl/inval_line_walker.sv
module inval_line_walker
    import aw_snoop_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LINE_W = 6,
    localparam int unsigned IDX_W = ADDR_W - LINE_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              q_empty_i,
    input  logic [IDX_W-1:0]  q_first_i,
    input  logic [IDX_W-1:0]  q_last_i,
    output logic              q_pop_o,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] addr_o
);
    walk_state_e      state_q, state_d;
    logic [IDX_W-1:0] cur_q, cur_d;
    logic [IDX_W-1:0] end_q, end_d;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= WK_IDLE;
            cur_q   <= '0;
            end_q   <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            end_q   <= end_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        end_d   = end_q;
        q_pop_o = 1'b0;
        if (!en_i) begin
            state_d = WK_IDLE;
        end else begin
            unique case (state_q)
                WK_IDLE: begin
                    if (!q_empty_i) begin
                        q_pop_o = 1'b1;
                        cur_d   = q_first_i;
                        end_d   = q_last_i;
                        state_d = WK_EMIT;
                    end
                end
                WK_EMIT: begin
                    if (ready_i) begin
                        if (cur_q != end_q) begin
                            cur_d = cur_q + 1'b1;
                        end else if (!q_empty_i) begin
                            q_pop_o = 1'b1;
                            cur_d   = q_first_i;
                            end_d   = q_last_i;
                        end else begin
                            state_d = WK_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    always_comb begin
        valid_o = (state_q == WK_EMIT) && en_i;
        addr_o  = {cur_q, {LINE_W{1'b0}}};
    end

    // R6
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && !ready_i) ##1 en_i |-> valid_o && $stable(addr_o));

    // R3
    line_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && ready_i && cur_q != end_q) ##1 en_i
        |-> valid_o && addr_o == $past(addr_o) + ADDR_W'(1 << LINE_W));

    // R9
    walker_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> state_q == WK_IDLE);

endmodule

// File: rtl/aw_snoop_inval.sv
module aw_snoop_inval
    import aw_snoop_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned LINE_BYTES = 64,
    parameter int unsigned Q_DEPTH    = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cons_en_i,
    input  logic              snoop_aw_valid_i,
    input  logic              snoop_aw_ready_i,
    input  logic [ADDR_W-1:0] snoop_aw_addr_i,
    input  logic [7:0]        snoop_aw_len_i,
    input  logic [2:0]        snoop_aw_size_i,
    input  logic [1:0]        snoop_aw_burst_i,
    output logic              inval_valid_o,
    output logic [ADDR_W-1:0] inval_addr_o,
    input  logic              inval_ready_i,
    output logic              aw_lost_o
);
    localparam int unsigned LINE_W = $clog2(LINE_BYTES);
    localparam int unsigned IDX_W  = ADDR_W - LINE_W;

    logic [IDX_W-1:0] span_first, span_last;
    logic [IDX_W-1:0] head_first, head_last;
    logic             q_empty, q_pop, aw_fire;

    assign aw_fire = snoop_aw_valid_i && snoop_aw_ready_i;

    aw_span_calc #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) i_span (
        .addr_i  (snoop_aw_addr_i),
        .len_i   (snoop_aw_len_i),
        .size_i  (snoop_aw_size_i),
        .burst_i (snoop_aw_burst_i),
        .first_o (span_first),
        .last_o  (span_last)
    );

    aw_burst_queue #(.DEPTH(Q_DEPTH), .IDX_W(IDX_W)) i_queue (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .en_i         (cons_en_i),
        .push_i       (aw_fire),
        .push_first_i (span_first),
        .push_last_i  (span_last),
        .pop_i        (q_pop),
        .empty_o      (q_empty),
        .head_first_o (head_first),
        .head_last_o  (head_last),
        .lost_o       (aw_lost_o)
    );

    inval_line_walker #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) i_walker (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (cons_en_i),
        .q_empty_i (q_empty),
        .q_first_i (head_first),
        .q_last_i  (head_last),
        .q_pop_o   (q_pop),
        .ready_i   (inval_ready_i),
        .valid_o   (inval_valid_o),
        .addr_o    (inval_addr_o)
    );

    // R8
    gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cons_en_i |-> !inval_valid_o);

    // R7
    first_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cons_en_i && aw_fire && q_empty && !inval_valid_o) ##1 cons_en_i
        |=> inval_valid_o);

endmodule

// File: tb/test_aw_snoop_inval.sv
`timescale 1ns/1ps
module test_aw_snoop_inval;
    localparam int unsigned AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          aw_valid = 1'b0, aw_ready = 1'b0;
    logic [AW-1:0] aw_addr = '0;
    logic [7:0]    aw_len = '0;
    logic [2:0]    aw_size = '0;
    logic [1:0]    aw_burst = 2'b01;
    logic          inv_valid, inv_ready, lost;
    logic [AW-1:0] inv_addr;

    int unsigned errors = 0, checks = 0;
    int unsigned cyc = 0, hs_count = 0, last_hs_cyc = 0, prev_hs_cyc = 0;
    int          rdy_mode = 1;
    string       cur_req = "R3";
    logic [7:0]  lfsr = 8'hA5;
    logic [AW-1:0] exp_q[$];

    always #10 clk = ~clk;

    aw_snoop_inval i_aw_snoop_inval (
        .clk_i(clk), .rst_ni(rst_n), .cons_en_i(en),
        .snoop_aw_valid_i(aw_valid), .snoop_aw_ready_i(aw_ready),
        .snoop_aw_addr_i(aw_addr), .snoop_aw_len_i(aw_len),
        .snoop_aw_size_i(aw_size), .snoop_aw_burst_i(aw_burst),
        .inval_valid_o(inv_valid), .inval_addr_o(inv_addr),
        .inval_ready_i(inv_ready), .aw_lost_o(lost)
    );
    assign inv_ready = (rdy_mode == 1) || (rdy_mode == 2 && (lfsr[0] | lfsr[3]));

    task automatic check(input string req, input logic ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model(input logic [AW-1:0] a, input logic [7:0] l,
                         input logic [2:0] s, input logic [1:0] b);
        longint unsigned bytes = (longint'(l) + 1) << s;
        longint unsigned lo = a, hi;
        if (b == 2'b00) hi = a;
        else begin
            if (b == 2'b10) lo = a & ~(bytes - 1);
            hi = lo + bytes - 1;
            if (hi > 64'hFFFF_FFFF) hi = 64'hFFFF_FFFF;
        end
        for (longint unsigned ln = lo >> 6; ln <= (hi >> 6); ln++)
            exp_q.push_back(AW'(ln << 6));
    endtask

    task automatic send(input logic [AW-1:0] a, input logic [7:0] l,
                        input logic [2:0] s, input logic [1:0] b, input bit expect_out);
        aw_addr = a; aw_len = l; aw_size = s; aw_burst = b;
        aw_valid = 1'b1; aw_ready = 1'b1;
        if (expect_out && en) model(a, l, s, b);
        @(negedge clk);
        aw_valid = 1'b0; aw_ready = 1'b0;
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 600 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (4) @(negedge clk);
        check(req, exp_q.size() == 0, exp_q.size(), 0);
    endtask

    // Scoreboard monitor: updates ready, then compares a handshake due at the next edge
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            #1;
            if (rst_n && inv_valid && inv_ready) begin
                hs_count++;
                prev_hs_cyc = last_hs_cyc;
                last_hs_cyc = cyc;
                if (exp_q.size() == 0) begin
                    check(cur_req, 1'b0, inv_addr, 0);
                end else begin
                    logic [AW-1:0] e;
                    e = exp_q.pop_front();
                    check(cur_req, inv_addr == e, inv_addr, e);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unsigned h0;
        repeat (3) @(negedge clk);
        check("R1", inv_valid == 1'b0, inv_valid, 0);
        check("R1", lost == 1'b0, lost, 0);
        rst_n = 1'b1; en = 1'b1;
        @(negedge clk);

        // R7 latency and R3 INCR
        cur_req = "R3"; rdy_mode = 1;
        send(32'h1000, 8'd3, 3'd3, 2'b01, 1);
        check("R7", inv_valid == 1'b0, inv_valid, 0);
        @(negedge clk);
        check("R7", inv_valid == 1'b1 && inv_addr == 32'h1000, inv_addr, 32'h1000);
        drain("R3");
        send(32'h103C, 8'd1, 3'd2, 2'b01, 1);
        drain("R3");
        rdy_mode = 2;
        send(32'h2010, 8'd15, 3'd4, 2'b01, 1);
        send(32'hFFFF_FFC8, 8'd7, 3'd3, 2'b01, 1);
        drain("R3");

        // R4 FIXED
        cur_req = "R4";
        send(32'h3008, 8'd7, 3'd3, 2'b00, 1);
        drain("R4");

        // R5 WRAP and reserved code
        cur_req = "R5";
        send(32'h4070, 8'd7, 3'd4, 2'b10, 1);
        send(32'h5020, 8'd1, 3'd5, 2'b11, 1);
        drain("R5");

        // R11 back-to-back chaining
        cur_req = "R11"; rdy_mode = 1;
        h0 = hs_count;
        send(32'h6000, 8'd0, 3'd2, 2'b01, 1);
        send(32'h7000, 8'd0, 3'd2, 2'b01, 1);
        drain("R11");
        check("R11", hs_count - h0 == 2, hs_count - h0, 2);
        check("R11", last_hs_cyc - prev_hs_cyc == 1, last_hs_cyc - prev_hs_cyc, 1);

        // R2 valid without ready
        cur_req = "R2";
        h0 = hs_count;
        aw_addr = 32'h8000; aw_len = 0; aw_size = 2; aw_burst = 2'b01;
        aw_valid = 1'b1; aw_ready = 1'b0;
        repeat (3) @(negedge clk);
        aw_valid = 1'b0;
        repeat (5) @(negedge clk);
        check("R2", hs_count == h0 && !inv_valid, hs_count - h0, 0);

        // R8 disabled path
        cur_req = "R8";
        en = 1'b0;
        send(32'h9000, 8'd3, 3'd4, 2'b01, 0);
        check("R8", inv_valid == 1'b0, inv_valid, 0);
        en = 1'b1;
        repeat (6) @(negedge clk);
        check("R8", hs_count == h0, hs_count - h0, 0);

        // R6 hold, R9 flush
        cur_req = "R9"; rdy_mode = 0;
        send(32'hA000, 8'd31, 3'd3, 2'b01, 0);
        send(32'hB000, 8'd0, 3'd2, 2'b01, 0);
        @(negedge clk);
        check("R6", inv_valid && inv_addr == 32'hA000, inv_addr, 32'hA000);
        repeat (3) @(negedge clk);
        check("R6", inv_valid && inv_addr == 32'hA000, inv_addr, 32'hA000);
        en = 1'b0;
        #1 check("R8", inv_valid == 1'b0, inv_valid, 0);
        @(negedge clk);
        en = 1'b1; rdy_mode = 1;
        repeat (8) @(negedge clk);
        check("R9", hs_count == h0 && !inv_valid, hs_count - h0, 0);

        // R10 overflow
        cur_req = "R10"; rdy_mode = 0;
        check("R10", lost == 1'b0, lost, 0);
        for (int i = 0; i < 6; i++)
            send(AW'(32'hC000 + i * 32'h100), 8'd0, 3'd2, 2'b01, i < 5);
        @(negedge clk);
        check("R10", lost == 1'b1, lost, 1);
        rdy_mode = 1;
        drain("R10");
        check("R10", lost == 1'b1, lost, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule